// File: doc/BRIEF.md
# Shadow-to-Active Register Load Controller

This block holds a small group of PWM timing registers (a period value and several compare values), each as a shadow/active pair. Software writes only the shadow copies. The block decides in which clock cycle the whole group is copied into the active copies, which the rest of the PWM then uses. A copy is triggered by a selectable time-base event:

- the counter reaching zero;
- the counter reaching the active period;
- an external sync pulse;
- the counter matching one of two auxiliary compare values while counting in a chosen direction.

A prescaler can make every Nth selected event trigger a copy, instead of every event.

Four load modes set the policy:

- **Immediate:** writes reach the active copy directly.
- **Continuous:** every qualified event loads.
- **One-shot:** one load follows each software arm.
- **Hold:** the active values are frozen.

Every load copies all registers in the same cycle, so a multiphase update is never seen half applied.

A tie-in write port lets a designated neighbour instance drive this instance's shadow writes. The block's own local write is also presented on outputs, so that other instances can follow it.

Top module: `shadow_load_ctrl`

## Requirements
- R1: Synchronous active-high reset clears every shadow and active register, the arm flag and the prescaler count. No load strobe is asserted during reset.
- R2: A write with `wr_addr`=k stores `wr_data` into shadow register k at the next edge. In immediate mode (`cfg_mode`=0) the same edge also stores it into active register k.
- R3: On a load strobe all NREG active registers take their shadow values at the same edge. Without a strobe no active register changes in modes 1 to 3.
- R4: `cfg_sel` picks the load event:
  - 0: `tb_cnt`==0.
  - 1: `tb_cnt` equals active register 0, which is the period.
  - 3: `tb_cnt`==`aux_c` with `tb_down`=0.
  - 4: `tb_cnt`==`aux_c` with `tb_down`=1.
  - 5: `tb_cnt`==`aux_d` with `tb_down`=0.
  - 6: `tb_cnt`==`aux_d` with `tb_down`=1.
  - 7: no event.
- R5: With prescale value `cfg_div`=d, a load occurs on the (d+1)th qualifying selected event. The earlier qualifying events only advance the count.
- R6: The prescaler count restarts at zero after every load. It also restarts in any cycle where {`cfg_mode`,`cfg_sel`,`cfg_div`} differs from its value in the previous cycle (all zero right after reset). No load can occur in such a cycle.
- R7: In one-shot mode (`cfg_mode`=2) a pulse on `arm` sets the arm flag. Exactly one load follows, which clears the flag. Further events cause no load until `arm` is pulsed again.
- R8: In continuous mode (`cfg_mode`=1) every prescaled event loads. In hold mode (`cfg_mode`=3) and immediate mode no load strobe is ever produced.
- R9: When a shadow write and a load strobe fall in the same cycle, the active register receives the previous shadow value and the new data stays in the shadow register.
- R10: With `cfg_link_en`=1 the shadow writes come only from the `lk_wr_*` port and local writes are ignored. The `tie_wr_*` outputs always mirror the local write port.
- R11: `cfg_sel`=2 makes a pulse on `ev_sync` the load event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 immediate, 1 continuous, 2 one-shot, 3 hold |
| cfg_sel | input | 3 | Load event selection code (see R4, R11) |
| cfg_div | input | PW | Prescale value d: load on every (d+1)th event |
| cfg_link_en | input | 1 | Take shadow writes from the tie-in port |
| arm | input | 1 | One-shot arm pulse |
| tb_cnt | input | W | Time-base counter value |
| tb_down | input | 1 | Time-base counting down |
| ev_sync | input | 1 | Sync event pulse |
| aux_c | input | W | First auxiliary compare value |
| aux_d | input | W | Second auxiliary compare value |
| wr_en | input | 1 | Local shadow write enable |
| wr_addr | input | AW | Local write register index |
| wr_data | input | W | Local write data |
| lk_wr_en | input | 1 | Tie-in write enable from the neighbour |
| lk_wr_addr | input | AW | Tie-in write register index |
| lk_wr_data | input | W | Tie-in write data |
| tie_wr_en | output | 1 | Mirror of local write enable |
| tie_wr_addr | output | AW | Mirror of local write index |
| tie_wr_data | output | W | Mirror of local write data |
| active_flat | output | NREG*W | Active registers; register i at bits [i*W +: W] |
| shadow_flat | output | NREG*W | Shadow registers; register i at bits [i*W +: W] |
| load_strobe | output | 1 | Load happens at the coming edge |
| armed | output | 1 | One-shot arm flag |

## Verification
Every cycle, the assertions check the following:
- a load clears the prescaler count;
- the count never passes the prescale value while the configuration is steady;
- a one-shot load drops the arm flag;
- immediate and hold modes never strobe;
- a strobe copies the whole shadow group into the active group;
- a write colliding with a strobe lands in the shadow register.

Some behaviours only the bench scenarios can show:
- which event each selection code reacts to, including the counting direction;
- the exact number of events per load;
- the count restart on a configuration change;
- one-shot re-arming;
- the link port overriding local writes.

The bench compares these against its behavioural model every cycle.

// File: rtl/shadow_load_pkg.sv
package shadow_load_pkg;

    typedef enum logic [1:0] {
        LM_IMM     = 2'd0,
        LM_CONT    = 2'd1,
        LM_ONESHOT = 2'd2,
        LM_HOLD    = 2'd3
    } ld_mode_e;

    typedef enum logic [2:0] {
        EV_ZERO   = 3'd0,
        EV_PERIOD = 3'd1,
        EV_SYNC   = 3'd2,
        EV_C_UP   = 3'd3,
        EV_C_DN   = 3'd4,
        EV_D_UP   = 3'd5,
        EV_D_DN   = 3'd6,
        EV_NONE   = 3'd7
    } ld_sel_e;

    // direction qualifier for auxiliary compare matches
    function automatic logic dir_ok(input logic want_down, input logic is_down);
        return want_down == is_down;
    endfunction

endpackage

// File: rtl/ld_evsel.sv
module ld_evsel #(
    parameter int W = 16
) (
    input  logic [2:0]   sel,
    input  logic [W-1:0] tb_cnt,
    input  logic         tb_down,
    input  logic [W-1:0] period_val,
    input  logic [W-1:0] aux_c,
    input  logic [W-1:0] aux_d,
    input  logic         sync_in,
    output logic         hit
);
    import shadow_load_pkg::*;

    logic match_c, match_d;

    assign match_c = (tb_cnt == aux_c);
    assign match_d = (tb_cnt == aux_d);

    always_comb begin
        unique case (ld_sel_e'(sel))
            EV_ZERO:   hit = (tb_cnt == '0);
            EV_PERIOD: hit = (tb_cnt == period_val);
            EV_SYNC:   hit = sync_in;
            EV_C_UP:   hit = match_c && dir_ok(1'b0, tb_down);
            EV_C_DN:   hit = match_c && dir_ok(1'b1, tb_down);
            EV_D_UP:   hit = match_d && dir_ok(1'b0, tb_down);
            EV_D_DN:   hit = match_d && dir_ok(1'b1, tb_down);
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ld_gate.sv
module ld_gate #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic [2:0]    sel,
    input  logic [PW-1:0] div,
    input  logic          arm_in,
    input  logic          hit,
    output logic          strobe,
    output logic          armed
);
    import shadow_load_pkg::*;

    localparam int CW = 2 + 3 + PW;

    logic [CW-1:0] cfg_q;
    logic [CW-1:0] cfg_now;
    logic          cfg_chg;
    logic [PW-1:0] cnt_q;
    logic          armed_q;
    logic          elig;
    logic          count_ev;

    assign cfg_now  = {mode, sel, div};
    assign cfg_chg  = (cfg_now != cfg_q);
    assign elig     = (ld_mode_e'(mode) == LM_CONT) ||
                      ((ld_mode_e'(mode) == LM_ONESHOT) && armed_q);
    assign count_ev = elig && hit && !cfg_chg;
    assign strobe   = !rst && count_ev && (cnt_q == div);
    assign armed    = armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            cfg_q   <= cfg_now;
            armed_q <= (armed_q && !strobe) || arm_in;
            if (cfg_chg || strobe)
                cnt_q <= '0;
            else if (count_ev)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: every load restarts the prescaler
    p_cnt_restart_r6: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (cnt_q == '0));

    // R5: count stays within the prescale range while config is steady
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        !cfg_chg |-> (cnt_q <= div));

    // R7: a one-shot load consumes the arm flag
    p_oneshot_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (strobe && !arm_in) |=> !armed_q);

    // R8: immediate and hold modes never strobe
    p_quiet_modes_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 || mode == 2'd3) |-> !strobe);
endmodule

// File: rtl/ld_bank.sv
module ld_bank #(
    parameter int W    = 16,
    parameter int NREG = 4,
    parameter int AW   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          imm_mode,
    input  logic          strobe,
    input  logic          link_en,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          lk_wr_en,
    input  logic [AW-1:0] lk_wr_addr,
    input  logic [W-1:0]  lk_wr_data,
    output logic [W-1:0]  period_val,
    output logic [NREG*W-1:0] act_flat,
    output logic [NREG*W-1:0] sh_flat
);
    logic          we;
    logic [AW-1:0] wa;
    logic [W-1:0]  wd;
    logic [W-1:0]  sh_q  [NREG];
    logic [W-1:0]  act_q [NREG];

    assign we = link_en ? lk_wr_en   : wr_en;
    assign wa = link_en ? lk_wr_addr : wr_addr;
    assign wd = link_en ? lk_wr_data : wr_data;

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            logic hit_i;
            assign hit_i = we && (wa == AW'(i));

            always_ff @(posedge clk) begin
                if (rst) begin
                    sh_q[i]  <= '0;
                    act_q[i] <= '0;
                end else begin
                    if (strobe)
                        act_q[i] <= sh_q[i];
                    if (hit_i) begin
                        sh_q[i] <= wd;
                        if (imm_mode)
                            act_q[i] <= wd;
                    end
                end
            end

            assign act_flat[i*W +: W] = act_q[i];
            assign sh_flat[i*W +: W]  = sh_q[i];

            // R3: all active registers follow their shadows on a strobe
            p_global_copy_r3: assert property (@(posedge clk) disable iff (rst)
                (strobe && !hit_i) |=> (act_q[i] == $past(sh_q[i])));

            // R9: a colliding write lands in the shadow, not the active copy
            p_collision_r9: assert property (@(posedge clk) disable iff (rst)
                (strobe && hit_i) |=> (sh_q[i] == $past(wd) &&
                                       act_q[i] == $past(sh_q[i])));
        end
    endgenerate

    assign period_val = act_q[0];
endmodule

// File: rtl/shadow_load_ctrl.sv
module shadow_load_ctrl #(
    parameter int W    = 16,
    parameter int NREG = 4,
    parameter int PW   = 4,
    parameter int AW   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic [2:0]        cfg_sel,
    input  logic [PW-1:0]     cfg_div,
    input  logic              cfg_link_en,
    input  logic              arm,
    input  logic [W-1:0]      tb_cnt,
    input  logic              tb_down,
    input  logic              ev_sync,
    input  logic [W-1:0]      aux_c,
    input  logic [W-1:0]      aux_d,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              lk_wr_en,
    input  logic [AW-1:0]     lk_wr_addr,
    input  logic [W-1:0]      lk_wr_data,
    output logic              tie_wr_en,
    output logic [AW-1:0]     tie_wr_addr,
    output logic [W-1:0]      tie_wr_data,
    output logic [NREG*W-1:0] active_flat,
    output logic [NREG*W-1:0] shadow_flat,
    output logic              load_strobe,
    output logic              armed
);
    import shadow_load_pkg::*;

    logic         hit;
    logic [W-1:0] period_val;
    logic         imm_mode;

    assign imm_mode    = (ld_mode_e'(cfg_mode) == LM_IMM);
    assign tie_wr_en   = wr_en;
    assign tie_wr_addr = wr_addr;
    assign tie_wr_data = wr_data;

    ld_evsel #(.W(W)) u_evsel (
        .sel        (cfg_sel),
        .tb_cnt     (tb_cnt),
        .tb_down    (tb_down),
        .period_val (period_val),
        .aux_c      (aux_c),
        .aux_d      (aux_d),
        .sync_in    (ev_sync),
        .hit        (hit)
    );

    ld_gate #(.PW(PW)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .mode   (cfg_mode),
        .sel    (cfg_sel),
        .div    (cfg_div),
        .arm_in (arm),
        .hit    (hit),
        .strobe (load_strobe),
        .armed  (armed)
    );

    ld_bank #(.W(W), .NREG(NREG), .AW(AW)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .imm_mode   (imm_mode),
        .strobe     (load_strobe),
        .link_en    (cfg_link_en),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .lk_wr_en   (lk_wr_en),
        .lk_wr_addr (lk_wr_addr),
        .lk_wr_data (lk_wr_data),
        .period_val (period_val),
        .act_flat   (active_flat),
        .sh_flat    (shadow_flat)
    );

    // R1: reset leaves the block quiet and disarmed
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!armed && active_flat == '0 && shadow_flat == '0));
endmodule

// File: tb/tb_shadow_load_ctrl.sv
module tb_shadow_load_ctrl;
    localparam int W = 16, NREG = 4, PW = 4, AW = 2;

    logic clk = 1'b0;
    logic rst;
    logic [1:0] cfg_mode;
    logic [2:0] cfg_sel;
    logic [PW-1:0] cfg_div;
    logic cfg_link_en, arm, tb_down, ev_sync;
    logic [W-1:0] tb_cnt, aux_c, aux_d;
    logic wr_en, lk_wr_en;
    logic [AW-1:0] wr_addr, lk_wr_addr;
    logic [W-1:0] wr_data, lk_wr_data;
    logic tie_wr_en;
    logic [AW-1:0] tie_wr_addr;
    logic [W-1:0] tie_wr_data;
    logic [NREG*W-1:0] active_flat, shadow_flat;
    logic load_strobe, armed;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    string cur_req = "R1";

    int m_sh[NREG];
    int m_act[NREG];
    int m_cnt, m_arm, m_prev;

    always #5 clk = ~clk;

    shadow_load_ctrl #(.W(W), .NREG(NREG), .PW(PW)) dut (.*);

    function automatic int act_of(int i);
        return int'(active_flat[i*W +: W]);
    endfunction
    function automatic int sh_of(int i);
        return int'(shadow_flat[i*W +: W]);
    endfunction

    task automatic chk(string req, int actual, int expected);
        vectors++;
        if (actual != expected) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
        end
    endtask

    function automatic bit model_event();
        int c = int'(tb_cnt);
        case (cfg_sel)
            3'd0: return c == 0;
            3'd1: return c == m_act[0];
            3'd2: return ev_sync;
            3'd3: return c == int'(aux_c) && !tb_down;
            3'd4: return c == int'(aux_c) && tb_down;
            3'd5: return c == int'(aux_d) && !tb_down;
            3'd6: return c == int'(aux_d) && tb_down;
            default: return 0;
        endcase
    endfunction

    // one clock: inputs already driven at the falling edge
    task automatic cyc();
        int key, we, wa, wd;
        bit chg, elig, ev, exp_strobe;
        #1;
        key  = int'(cfg_mode) * 1000 + int'(cfg_sel) * 100 + int'(cfg_div);
        chg  = (key != m_prev);
        elig = (cfg_mode == 2'd1) || (cfg_mode == 2'd2 && m_arm != 0);
        ev   = model_event();
        exp_strobe = !rst && !chg && elig && ev && (m_cnt == int'(cfg_div));
        vectors++;
        if (load_strobe !== exp_strobe || armed !== (m_arm != 0)) begin
            miscompares++;
            $display("FAIL %s: strobe/armed actual %0b/%0b expected %0b/%0b",
                     cur_req, load_strobe, armed, exp_strobe, m_arm != 0);
        end
        for (int i = 0; i < NREG; i++) begin
            if (act_of(i) != m_act[i] || sh_of(i) != m_sh[i]) begin
                miscompares++;
                $display("FAIL %s: reg%0d act/sh actual %0h/%0h expected %0h/%0h",
                         cur_req, i, act_of(i), sh_of(i), m_act[i], m_sh[i]);
            end
        end
        if (rst) begin
            foreach (m_sh[i]) begin m_sh[i] = 0; m_act[i] = 0; end
            m_cnt = 0; m_arm = 0; m_prev = 0;
        end else begin
            we = cfg_link_en ? lk_wr_en : wr_en;
            wa = cfg_link_en ? int'(lk_wr_addr) : int'(wr_addr);
            wd = cfg_link_en ? int'(lk_wr_data) : int'(wr_data);
            if (exp_strobe) foreach (m_act[i]) m_act[i] = m_sh[i];
            if (we != 0) begin
                m_sh[wa] = wd;
                if (cfg_mode == 2'd0) m_act[wa] = wd;
            end
            if (chg || exp_strobe) m_cnt = 0;
            else if (elig && ev) m_cnt++;
            m_arm = ((m_arm != 0) && !exp_strobe) || arm;
            m_prev = key;
        end
        @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        wr_en = 1; wr_addr = AW'(a); wr_data = W'(d);
        cyc();
        wr_en = 0;
    endtask

    task automatic zero_ev();
        tb_cnt = 0; cyc(); tb_cnt = 5; cyc();
    endtask

    task automatic setcfg(int md, int sl, int dv);
        cfg_mode = 2'(md); cfg_sel = 3'(sl); cfg_div = PW'(dv);
        cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1; cfg_mode = 0; cfg_sel = 0; cfg_div = 0; cfg_link_en = 0;
        arm = 0; tb_cnt = 5; tb_down = 0; ev_sync = 0; aux_c = 50; aux_d = 70;
        wr_en = 0; wr_addr = 0; wr_data = 0; lk_wr_en = 0; lk_wr_addr = 0; lk_wr_data = 0;
        m_cnt = 0; m_arm = 0; m_prev = 0;
        foreach (m_sh[i]) begin m_sh[i] = 0; m_act[i] = 0; end
        @(negedge clk);
        cyc(); cyc();
        rst = 0;
        // R1 reset state
        chk("R1", act_of(1), 0); chk("R1", sh_of(3), 0); chk("R1", int'(armed), 0);

        // R2 immediate writes
        cur_req = "R2";
        wr(1, 'h1111); chk("R2", act_of(1), 'h1111); chk("R2", sh_of(1), 'h1111);
        wr(0, 100);

        // R3 global load on zero event, continuous mode
        cur_req = "R3";
        setcfg(1, 0, 0);
        wr(0, 200); wr(1, 'h2222); wr(2, 'h3333); wr(3, 'h4444);
        chk("R3", act_of(1), 'h1111);
        zero_ev();
        chk("R3", act_of(0), 200); chk("R3", act_of(1), 'h2222);
        chk("R3", act_of(2), 'h3333); chk("R3", act_of(3), 'h4444);

        // R4 period event
        cur_req = "R4";
        setcfg(1, 1, 0);
        wr(1, 'h5555);
        tb_cnt = 200; cyc(); tb_cnt = 5; cyc();
        chk("R4", act_of(1), 'h5555);
        // R4 aux C up-count
        setcfg(1, 3, 0);
        wr(2, 'h6666);
        tb_cnt = 50; tb_down = 1; cyc();
        chk("R4", act_of(2), 'h3333);
        tb_down = 0; cyc(); tb_cnt = 5;
        chk("R4", act_of(2), 'h6666);
        // R4 aux D down-count
        setcfg(1, 6, 0);
        wr(2, 'h7777);
        tb_cnt = 70; tb_down = 0; cyc();
        chk("R4", act_of(2), 'h6666);
        tb_down = 1; cyc(); tb_cnt = 5; tb_down = 0;
        chk("R4", act_of(2), 'h7777);

        // R5 prescaler: every third zero event
        cur_req = "R5";
        setcfg(1, 0, 2);
        wr(3, 'h8888);
        zero_ev(); chk("R5", act_of(3), 'h4444);
        zero_ev(); chk("R5", act_of(3), 'h4444);
        zero_ev(); chk("R5", act_of(3), 'h8888);

        // R6 count restart on configuration change
        cur_req = "R6";
        wr(3, 'h9999);
        zero_ev(); zero_ev();
        setcfg(1, 0, 1);
        zero_ev(); chk("R6", act_of(3), 'h8888);
        zero_ev(); chk("R6", act_of(3), 'h9999);

        // R11 sync event
        cur_req = "R11";
        setcfg(1, 2, 0);
        wr(0, 300);
        ev_sync = 1; cyc(); ev_sync = 0; cyc();
        chk("R11", act_of(0), 300);

        // R7 one-shot
        cur_req = "R7";
        setcfg(2, 0, 0);
        wr(1, 'hAAAA);
        zero_ev(); chk("R7", act_of(1), 'h5555);
        arm = 1; cyc(); arm = 0;
        chk("R7", int'(armed), 1);
        zero_ev(); chk("R7", act_of(1), 'hAAAA); chk("R7", int'(armed), 0);
        wr(1, 'hBBBB);
        zero_ev(); chk("R7", act_of(1), 'hAAAA);

        // R8 hold mode freezes active values
        cur_req = "R8";
        setcfg(3, 0, 0);
        zero_ev(); chk("R8", act_of(1), 'hAAAA);

        // R9 write colliding with load
        cur_req = "R9";
        setcfg(1, 0, 0);
        tb_cnt = 0; wr(2, 'hCCCC); tb_cnt = 5; cyc();
        chk("R9", act_of(2), 'h7777); chk("R9", sh_of(2), 'hCCCC);
        chk("R8", act_of(1), 'hBBBB);
        zero_ev(); chk("R9", act_of(2), 'hCCCC);

        // R10 tie-in port
        cur_req = "R10";
        cfg_link_en = 1;
        lk_wr_en = 1; lk_wr_addr = 3; lk_wr_data = 'hDDDD;
        wr_en = 1; wr_addr = 3; wr_data = 'hEEEE;
        #1;
        chk("R10", int'(tie_wr_en), 1); chk("R10", int'(tie_wr_data), 'hEEEE);
        chk("R10", int'(tie_wr_addr), 3);
        cyc();
        lk_wr_en = 0; wr_en = 0;
        chk("R10", sh_of(3), 'hDDDD);
        wr(2, 'h1234);
        chk("R10", sh_of(2), 'hCCCC);
        cfg_link_en = 0;
        cyc();

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule